// File: doc/BRIEF.md
# Parallel-Port Host Data Multiplexer

This block sits on the device side of a legacy parallel port. The host uses two control lines to choose what the device places on the 8-bit data bus. The choices are a channel A sample, a channel B sample, a shared mailbox byte, or a fixed identity pattern. A third control line, the strobe, does two jobs depending on the selection. While a sample channel is selected, each strobe pulse steps a readout pointer through the sample window, which wraps at its top. While the mailbox is selected and the host is driving the bus, the strobe stores the host's byte in the mailbox.

The mailbox works in one direction at a time, and zero means "nothing new". When one side writes, that side reads zero until the other side writes back. The command sequencer uses the device side of the mailbox and can rewind the readout pointer before a new readout. Sample memory receives the pointer and returns one byte per channel. In scroll mode the channel selections show the live converter bytes instead of memory contents. All host control inputs pass through a two-flop synchroniser, and the strobe is edge-detected, so one host pulse counts once however long it lasts.

Top module: `pp_host_mux`

## Requirements
- R1: After reset, `rd_addr` is 0x4000, `bus_oe` is 0, `dev_full` is 0 and `dev_rdata` is 0.
- R2: With `host_selin`=0 and `host_feed`=0, `bus_dout` carries `mem_a`, the channel A byte at `rd_addr`.
- R3: With `host_selin`=0 and `host_feed`=1, `bus_dout` carries `mem_b`, the channel B byte at `rd_addr`.
- R4: With `host_selin`=1 and `host_feed`=0, `bus_dout` carries the host view of the mailbox. This is 0 while the mailbox is empty for the host.
- R5: With `host_selin`=1 and `host_feed`=1, `bus_dout` carries the constant 0x55.
- R6: `bus_oe` is 1 while the synchronised `host_drive` is 0, and 0 while it is 1.
- R7: A rising edge on `host_strobe` while `host_selin`=0 and `scroll`=0 advances `rd_addr` by exactly one, however wide the pulse is.
- R8: An advance from 0x7FFF takes `rd_addr` to 0x4000.
- R9: `rewind` sets `rd_addr` to 0x4000 on the next clock and takes priority over an advance.
- R10: A strobe edge while the mailbox is selected and `host_drive`=1 stores `host_din`. After that, `dev_full`=1, `dev_rdata` shows the byte, and the host view reads 0.
- R11: `dev_wr` stores `dev_wdata` for the host to read. After that, `dev_full`=0, `dev_rdata` reads 0, and the host view shows the byte.
- R12: With `scroll`=1, channel A and channel B show `adc_a` and `adc_b`, and strobes do not move `rd_addr`.
- R13: A strobe while the identity pattern is selected, or while the mailbox is selected with `host_drive`=0, changes neither `rd_addr` nor the mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe | input | 1 | Host strobe, active high |
| host_feed | input | 1 | Host select line 0 (channel B / identity) |
| host_selin | input | 1 | Host select line 1 (mailbox / identity) |
| host_drive | input | 1 | 1 while the host drives the data bus |
| host_din | input | 8 | Data bus as driven by the host |
| bus_dout | output | 8 | Data the device presents to the bus |
| bus_oe | output | 1 | Device bus driver enable |
| rd_addr | output | 15 | Sample readout address |
| mem_a | input | 8 | Channel A memory byte at `rd_addr` |
| mem_b | input | 8 | Channel B memory byte at `rd_addr` |
| scroll | input | 1 | Live converter mode |
| adc_a | input | 8 | Live channel A converter byte |
| adc_b | input | 8 | Live channel B converter byte |
| rewind | input | 1 | Sequencer request to reset the pointer |
| dev_wr | input | 1 | Sequencer writes the mailbox |
| dev_wdata | input | 8 | Byte the sequencer writes |
| dev_rdata | output | 8 | Device view of the mailbox |
| dev_full | output | 1 | A host byte is waiting for the device |

## Verification
The assertions check on every cycle that the pointer stays inside the window, moves by at most one step, wraps only from the top, returns to the base on rewind, and holds still in scroll mode. They also check that the device view of the mailbox reads zero whenever no host byte is waiting. Only the bench scenarios can show which source the output selection presents for each control code, that a wide strobe counts once, that the host reads zero after its own write, and that strobes on the identity or reading selections are ignored.

// File: rtl/pp_host_mux.sv
module pp_host_mux #(
  parameter int DW = 8,
  parameter int AW = 15,
  parameter logic [AW-1:0] BASE = 15'h4000,
  parameter logic [AW-1:0] TOP = 15'h7FFF,
  parameter logic [DW-1:0] ID = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_strobe,
  input  logic          host_feed,
  input  logic          host_selin,
  input  logic          host_drive,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] mem_a,
  input  logic [DW-1:0] mem_b,
  input  logic          scroll,
  input  logic [DW-1:0] adc_a,
  input  logic [DW-1:0] adc_b,
  input  logic          rewind,
  input  logic          dev_wr,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_full
);

  localparam logic [3:0] CTL_RST = 4'b1000;

  logic [3:0] ctl_m, ctl_s;
  logic       stb_q;
  logic [DW-1:0] mb_val;
  logic          mb_host;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_m <= CTL_RST;
      ctl_s <= CTL_RST;
      stb_q <= 1'b0;
    end else begin
      ctl_m <= {host_drive, host_selin, host_feed, host_strobe};
      ctl_s <= ctl_m;
      stb_q <= ctl_s[0];
    end
  end

  wire drv_s   = ctl_s[3];
  wire sel_s   = ctl_s[2];
  wire feed_s  = ctl_s[1];
  wire stb_up  = ctl_s[0] & ~stb_q;
  wire on_smp  = ~sel_s;
  wire on_mb   = sel_s & ~feed_s;
  wire advance = stb_up & on_smp & ~scroll;
  wire host_wr = stb_up & on_mb & drv_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_addr <= BASE;
    else if (rewind)
      rd_addr <= BASE;
    else if (advance)
      rd_addr <= (rd_addr == TOP) ? BASE : rd_addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_val  <= '0;
      mb_host <= 1'b0;
    end else if (dev_wr) begin
      mb_val  <= dev_wdata;
      mb_host <= 1'b0;
    end else if (host_wr) begin
      mb_val  <= host_din;
      mb_host <= 1'b1;
    end
  end

  wire [DW-1:0] ch_a = scroll ? adc_a : mem_a;
  wire [DW-1:0] ch_b = scroll ? adc_b : mem_b;
  wire [DW-1:0] mb_host_view = mb_host ? '0 : mb_val;

  always_comb begin
    case ({sel_s, feed_s})
      2'b00:   bus_dout = ch_a;
      2'b01:   bus_dout = ch_b;
      2'b10:   bus_dout = mb_host_view;
      default: bus_dout = ID;
    endcase
  end

  assign bus_oe    = ~drv_s;
  assign dev_full  = mb_host;
  assign dev_rdata = mb_host ? mb_val : '0;

endmodule

module pp_host_mux_chk #(
  parameter int DW = 8,
  parameter int AW = 15,
  parameter logic [AW-1:0] BASE = 15'h4000,
  parameter logic [AW-1:0] TOP = 15'h7FFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rewind,
  input logic          scroll,
  input logic [AW-1:0] rd_addr,
  input logic          dev_full,
  input logic [DW-1:0] dev_rdata
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr >= BASE && rd_addr <= TOP);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind && rd_addr != TOP) |=>
      (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + ONE));

  a_r8_wrap_only_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!rewind && rd_addr == TOP) |=> (rd_addr == TOP || rd_addr == BASE));

  a_r9_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> rd_addr == BASE);

  a_r12_scroll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scroll && !rewind) |=> rd_addr == $past(rd_addr));

  a_r11_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_full |-> dev_rdata == '0);

endmodule

bind pp_host_mux pp_host_mux_chk #(.DW(DW), .AW(AW), .BASE(BASE), .TOP(TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rewind(rewind), .scroll(scroll),
  .rd_addr(rd_addr), .dev_full(dev_full), .dev_rdata(dev_rdata)
);

// File: tb/pp_host_mux_bench.sv
module pp_host_mux_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_strobe = 0, host_feed = 0, host_selin = 0, host_drive = 1;
  logic [7:0] host_din = 0, adc_a = 0, adc_b = 0, dev_wdata = 0;
  logic scroll = 0, rewind = 0, dev_wr = 0;
  logic [7:0] bus_dout, dev_rdata, mem_a, mem_b;
  logic bus_oe, dev_full;
  logic [14:0] rd_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  always #(CLK_NS/2) clk = ~clk;

  assign mem_a = rd_addr[7:0] ^ 8'hA5;
  assign mem_b = rd_addr[7:0] + 8'h3C;

  pp_host_mux u_pp_host_mux (
    .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_feed(host_feed),
    .host_selin(host_selin), .host_drive(host_drive), .host_din(host_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .rd_addr(rd_addr), .mem_a(mem_a),
    .mem_b(mem_b), .scroll(scroll), .adc_a(adc_a), .adc_b(adc_b),
    .rewind(rewind), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_full(dev_full)
  );

  function automatic logic [7:0] a_at(logic [14:0] ad); return ad[7:0] ^ 8'hA5; endfunction
  function automatic logic [7:0] b_at(logic [14:0] ad); return ad[7:0] + 8'h3C; endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always begin
    @(mon_ev);
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({24'd0, bus_dout}, {24'd0, e}, t);
    end
  end

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic want_bus(logic [7:0] v, string tag);
    settle();
    exp_q.push_back(v);
    tag_q.push_back(tag);
    ->mon_ev;
    #1;
  endtask

  task automatic sel(logic s, logic f); @(negedge clk); host_selin = s; host_feed = f; endtask

  task automatic pulse(int hi);
    @(negedge clk) host_strobe = 1;
    repeat (hi) @(negedge clk);
    host_strobe = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic dev_write(logic [7:0] v);
    @(negedge clk) begin dev_wr = 1; dev_wdata = v; end
    @(negedge clk) dev_wr = 0;
  endtask

  initial begin
    repeat (200000 - 1000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_addr, 32'h4000, "R1 addr");
    chk(bus_oe, 0, "R1 oe");
    chk(dev_full, 0, "R1 full");
    chk(dev_rdata, 0, "R1 rdata");

    @(negedge clk) host_drive = 0;
    settle();
    chk(bus_oe, 1, "R6 oe on");
    sel(0, 0); want_bus(a_at(15'h4000), "R2 chan A");
    sel(0, 1); want_bus(b_at(15'h4000), "R3 chan B");
    sel(1, 1); want_bus(8'h55, "R5 identity");

    sel(0, 0); pulse(3);
    chk(rd_addr, 32'h4001, "R7 step");
    want_bus(a_at(15'h4001), "R7 chan A after step");
    pulse(12);
    chk(rd_addr, 32'h4002, "R7 wide pulse once");
    sel(0, 1); pulse(3);
    want_bus(b_at(15'h4003), "R7 chan B after step");

    sel(1, 0); want_bus(8'h00, "R4 empty mailbox");
    dev_write(8'h21);
    want_bus(8'h21, "R11 host sees device byte");
    chk(dev_full, 0, "R11 full low");
    chk(dev_rdata, 0, "R11 device reads zero");

    @(negedge clk) begin host_drive = 1; host_din = 8'h99; end
    pulse(3);
    settle();
    chk(dev_full, 1, "R10 full");
    chk(dev_rdata, 8'h99, "R10 device byte");
    @(negedge clk) host_drive = 0;
    want_bus(8'h00, "R10 host reads zero");

    dev_write(8'h03);
    @(negedge clk) host_din = 8'h77;
    pulse(3);
    want_bus(8'h03, "R13 read strobe keeps mailbox");
    chk(dev_full, 0, "R13 no latch when reading");

    sel(1, 1); pulse(3);
    chk(rd_addr, 32'h4003, "R13 identity strobe no step");

    sel(0, 0);
    @(negedge clk) rewind = 1;
    @(negedge clk) rewind = 0;
    chk(rd_addr, 32'h4000, "R9 rewind");

    for (int i = 0; i < 16383; i++) pulse(2);
    chk(rd_addr, 32'h7FFF, "R8 top");
    pulse(2);
    chk(rd_addr, 32'h4000, "R8 wrap");

    @(negedge clk) begin scroll = 1; adc_a = 8'h3C; adc_b = 8'hC3; end
    want_bus(8'h3C, "R12 live A");
    sel(0, 1); want_bus(8'hC3, "R12 live B");
    pulse(3);
    chk(rd_addr, 32'h4000, "R12 no step");

    @(negedge clk) host_drive = 1;
    settle();
    chk(bus_oe, 0, "R6 oe off");

    done = 1;
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule